// File: doc/BRIEF.md
# Lossy Last-Value Fast Channel Bank

This block is a bank of word-wide channels shared by a sending agent and a receiving agent. The sender writes any channel at any moment. There is no flow control, and a newer value silently replaces one the receiver has not read. The receiver reads whichever channel it likes and always gets the most recent word stored there.

Every write marks its channel as pending. A pending channel drives a level interrupt unless the receiver has masked it. The receiver clears pending bits with a per-channel clear vector. A second interrupt layer ORs the masked pending bits of each consecutive set of 32 channels into one group line, so a receiver can service many channels through a few interrupt inputs.

The word width and channel count are parameters. The supported limit is 1024 channels for 32-bit words and 512 channels for 64-bit words. Channels are numbered from 0.

Top module: `fch_bank`

## Requirements
- R1: After reset every channel reads as zero, no channel is pending, and every channel and group interrupt output is low.
- R2: `rd_data` is registered. It shows the word stored in channel `rd_ch` as of the clock edge that samples `rd_ch`. A write made at an earlier edge is visible.
- R3: A later write to a channel replaces the earlier word, whether or not that word was read. A read returns only the latest word.
- R4: A write to channel c sets the pending bit of channel c and of no other channel. The pending bit is set at the write edge, so `ch_irq[c]` goes high after that edge if channel c is unmasked.
- R5: A pending bit stays set through any number of further writes. A single clear removes it, because no count of overwrites is kept.
- R6: Setting `ch_clr[c]` for one cycle clears the pending bit of channel c at that edge. Clearing a channel that is not pending has no effect on any output.
- R7: If a write to channel c and `ch_clr[c]` occur in the same cycle, the write wins and channel c stays pending.
- R8: `ch_irq[c]` is high only when channel c is pending and `ch_mask[c]` is 0 (a mask bit of 1 hides the channel). Masking does not discard the pending state, so clearing the mask bit raises the interrupt again.
- R9: `grp_irq[g]` is high exactly when any of channels 32*g through 32*g+31 has its `ch_irq` bit high.
- R10: Reading a channel does not change any pending bit or interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Sender write strobe |
| wr_ch | input | CH_W | Channel written by the sender |
| wr_data | input | WORD_W | Word written by the sender |
| rd_ch | input | CH_W | Channel read by the receiver |
| rd_data | output | WORD_W | Registered read word |
| ch_clr | input | NUM_CH | Per-channel pending clear, one cycle per clear |
| ch_mask | input | NUM_CH | Per-channel interrupt mask, 1 hides the channel |
| ch_irq | output | NUM_CH | Per-channel level interrupt |
| grp_irq | output | NUM_GRP | Per-group level interrupt, 32 channels per group |

## Verification
The hardest conditions to reach from the ports are the collisions: a write and a clear landing on the same channel in the same cycle, and several writes arriving before any read. The stimulus drives both strobes in a single cycle to create the first. It stacks back-to-back writes to one channel before reading it to create the second. Group coverage is reached by making channels pending one at a time at group boundaries (31, 32, 63), then masking and clearing them individually. This shows that each group line follows only its own members.

// File: rtl/fch_pkg.sv
package fch_pkg;
  // number of groups needed to cover a channel count
  function automatic int unsigned grp_count(int unsigned nch, int unsigned gsz);
    return (nch + gsz - 1) / gsz;
  endfunction

  // next pending state of one channel: a write sets it and dominates a clear
  function automatic logic pend_next(logic cur, logic clr, logic hit);
    return (cur & ~clr) | hit;
  endfunction

  // largest legal channel count for a word width
  function automatic int unsigned max_channels(int unsigned word_w);
    return (word_w == 64) ? 512 : 1024;
  endfunction
endpackage

// File: rtl/fch_store.sv
module fch_store #(
  parameter int WORD_W = 32,
  parameter int NUM_CH = 64,
  parameter int CH_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [NUM_CH];
  logic              wr_ok;
  logic              rd_ok;

  assign wr_ok = wr_en && (int'(wr_ch) < NUM_CH);
  assign rd_ok = int'(rd_ch) < NUM_CH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[wr_ch] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_ok) rd_data <= mem[rd_ch];
    else            rd_data <= '0;
  end
endmodule

// File: rtl/fch_pend.sv
module fch_pend #(
  parameter int NUM_CH = 64,
  parameter int CH_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [NUM_CH-1:0] ch_clr,
  output logic [NUM_CH-1:0] wr_hit,
  output logic [NUM_CH-1:0] pend_q
);
  import fch_pkg::*;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign wr_hit[i] = wr_en && (wr_ch == CH_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_next(pend_q[i], ch_clr[i], wr_hit[i]);
    end
  end
endmodule

// File: rtl/fch_group.sv
module fch_group #(
  parameter int NUM_CH  = 64,
  parameter int GRP_SZ  = 32,
  parameter int NUM_GRP = 2
) (
  input  logic [NUM_CH-1:0]  ch_irq,
  output logic [NUM_GRP-1:0] grp_irq
);
  localparam int PAD_W = NUM_GRP * GRP_SZ;
  logic [PAD_W-1:0] padded;

  assign padded = PAD_W'(ch_irq);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_irq[g] = |padded[g*GRP_SZ +: GRP_SZ];
  end
endmodule

// File: rtl/fch_bank.sv
module fch_bank #(
  parameter int WORD_W  = 32,
  parameter int NUM_CH  = 64,
  parameter int GRP_SZ  = 32,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int NUM_GRP = fch_pkg::grp_count(NUM_CH, GRP_SZ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CH_W-1:0]    wr_ch,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [CH_W-1:0]    rd_ch,
  output logic [WORD_W-1:0]  rd_data,
  input  logic [NUM_CH-1:0]  ch_clr,
  input  logic [NUM_CH-1:0]  ch_mask,
  output logic [NUM_CH-1:0]  ch_irq,
  output logic [NUM_GRP-1:0] grp_irq
);
  // internal events brought out for the checker
  logic [NUM_CH-1:0] wr_hit;
  logic [NUM_CH-1:0] pend_q;

  fch_store #(.WORD_W(WORD_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_data(wr_data), .rd_ch(rd_ch), .rd_data(rd_data)
  );

  fch_pend #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
    .ch_clr(ch_clr), .wr_hit(wr_hit), .pend_q(pend_q)
  );

  assign ch_irq = pend_q & ~ch_mask;

  fch_group #(.NUM_CH(NUM_CH), .GRP_SZ(GRP_SZ), .NUM_GRP(NUM_GRP)) u_group (
    .ch_irq(ch_irq), .grp_irq(grp_irq)
  );
endmodule

// File: rtl/fch_bank_chk.sv
module fch_bank_chk #(
  parameter int NUM_CH  = 64,
  parameter int GRP_SZ  = 32,
  parameter int NUM_GRP = 2,
  parameter int CH_W    = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [CH_W-1:0]    wr_ch,
  input logic [NUM_CH-1:0]  ch_clr,
  input logic [NUM_CH-1:0]  ch_mask,
  input logic [NUM_CH-1:0]  wr_hit,
  input logic [NUM_CH-1:0]  pend_q,
  input logic [NUM_CH-1:0]  ch_irq,
  input logic [NUM_GRP-1:0] grp_irq
);
  localparam int PAD_W = NUM_GRP * GRP_SZ;
  logic [PAD_W-1:0] irq_pad;
  assign irq_pad = PAD_W'(ch_irq);

  // R4
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  // R4
  wr_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pend_q[$past(wr_ch)]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R5
    hold_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !ch_clr[i]) |=> pend_q[i]);
    // R6
    clear_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_clr[i] && !wr_hit[i]) |=> !pend_q[i]);
    // R7
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |=> pend_q[i]);
    // R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(wr_hit[i]));
    // R8
    mask_hides_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mask[i] || !pend_q[i]) |-> !ch_irq[i]);
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    // R9
    grp_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_irq[g] == (|irq_pad[g*GRP_SZ +: GRP_SZ]));
  end
endmodule

bind fch_bank fch_bank_chk #(
  .NUM_CH(NUM_CH), .GRP_SZ(GRP_SZ), .NUM_GRP(NUM_GRP), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
  .ch_clr(ch_clr), .ch_mask(ch_mask), .wr_hit(wr_hit), .pend_q(pend_q),
  .ch_irq(ch_irq), .grp_irq(grp_irq)
);

// File: tb/fch_bank_tb.sv
module fch_bank_tb;
  localparam int WORD_W = 32;
  localparam int NUM_CH = 64;
  localparam int GRP_SZ = 32;
  localparam int CH_W   = 6;
  localparam int NGRP   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [CH_W-1:0]   wr_ch = '0;
  logic [WORD_W-1:0] wr_data = '0;
  logic [CH_W-1:0]   rd_ch = '0;
  logic [WORD_W-1:0] rd_data;
  logic [NUM_CH-1:0] ch_clr = '0;
  logic [NUM_CH-1:0] ch_mask = '0;
  logic [NUM_CH-1:0] ch_irq;
  logic [NGRP-1:0]   grp_irq;

  always #5 clk = ~clk;

  fch_bank #(.WORD_W(WORD_W), .NUM_CH(NUM_CH), .GRP_SZ(GRP_SZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_data(rd_data), .ch_clr(ch_clr), .ch_mask(ch_mask),
    .ch_irq(ch_irq), .grp_irq(grp_irq)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [WORD_W-1:0] m_mem [NUM_CH];
  logic [NUM_CH-1:0] m_pend = '0;

  typedef struct {
    int                ch;
    logic [WORD_W-1:0] exp;
    string             req;
  } rd_item_t;
  rd_item_t rd_q[$];

  // monitor: compares each read a little after the edge that captured it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rd_q.size() > 0) begin
        rd_item_t it;
        it = rd_q.pop_front();
        n_run++;
        if (rd_data !== it.exp) begin
          n_fail++;
          $display("FAIL %s read ch%0d: actual %h expected %h", it.req, it.ch, rd_data, it.exp);
        end
      end
    end
  end

  function automatic logic [NGRP-1:0] exp_grp(logic [NUM_CH-1:0] irqs);
    logic [NGRP-1:0] r = '0;
    for (int c = 0; c < NUM_CH; c++) if (irqs[c]) r[c / GRP_SZ] = 1'b1;
    return r;
  endfunction

  // one cycle of sender/receiver activity; model updated after the edge
  task automatic step(input bit we, input int ch, input logic [WORD_W-1:0] d,
                      input logic [NUM_CH-1:0] clr);
    @(negedge clk);
    wr_en = we; wr_ch = CH_W'(ch); wr_data = d; ch_clr = clr;
    @(posedge clk);
    #1;
    m_pend = m_pend & ~clr;
    if (we) begin
      m_pend[ch] = 1'b1;
      m_mem[ch] = d;
    end
    wr_en = 1'b0; ch_clr = '0;
  endtask

  task automatic wr(input int ch, input logic [WORD_W-1:0] d);
    step(1'b1, ch, d, '0);
  endtask

  task automatic clr1(input int ch);
    logic [NUM_CH-1:0] v = '0;
    v[ch] = 1'b1;
    step(1'b0, 0, '0, v);
  endtask

  task automatic rd(input int ch, input string req);
    rd_item_t it;
    @(negedge clk);
    rd_ch = CH_W'(ch);
    it.ch = ch; it.exp = m_mem[ch]; it.req = req;
    rd_q.push_back(it);
    @(posedge clk);
    #3;
  endtask

  task automatic chk_irq(input string req);
    logic [NUM_CH-1:0] ei;
    @(negedge clk);
    ei = m_pend & ~ch_mask;
    n_run++;
    if (ch_irq !== ei || grp_irq !== exp_grp(ei)) begin
      n_fail++;
      $display("FAIL %s irq: actual %h/%b expected %h/%b", req, ch_irq, grp_irq, ei, exp_grp(ei));
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_CH; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    chk_irq("R1");
    rd(0, "R1");
    rd(63, "R1");

    // R2 / R4: single write
    wr(5, 32'hA5A5_0001);
    chk_irq("R4");
    rd(5, "R2");

    // R3 / R5: overwrite without read, pending stays set
    wr(5, 32'h0000_BEEF);
    wr(5, 32'h1234_5678);
    chk_irq("R5");
    rd(5, "R3");
    // R10: reading leaves pending in place
    chk_irq("R10");

    // R5 / R6: one clear removes a pending bit hit many times
    clr1(5);
    chk_irq("R6");

    // R6: clearing an idle channel changes nothing
    wr(40, 32'h4040_4040);
    clr1(7);
    chk_irq("R6");
    rd(40, "R6");
    clr1(40);

    // R7: write and clear on the same channel in one cycle
    begin
      logic [NUM_CH-1:0] v = '0;
      v[9] = 1'b1;
      step(1'b1, 9, 32'h0909_0909, v);
    end
    chk_irq("R7");

    // R8: mask hides, unmask reveals
    @(negedge clk); ch_mask[9] = 1'b1;
    chk_irq("R8");
    @(negedge clk); ch_mask[9] = 1'b0;
    chk_irq("R8");
    clr1(9);

    // R9: group boundaries
    wr(31, 32'h3131_3131);
    chk_irq("R9");
    wr(32, 32'h3232_3232);
    chk_irq("R9");
    clr1(31);
    chk_irq("R9");
    wr(63, 32'h6363_6363);
    @(negedge clk); ch_mask[32] = 1'b1;
    chk_irq("R9");
    @(negedge clk); ch_mask[63] = 1'b1;
    chk_irq("R9");
    @(negedge clk); ch_mask = '0;
    clr1(32);
    clr1(63);
    chk_irq("R9");

    // R2: data pattern over every channel, read back in reverse order
    for (int c = 0; c < NUM_CH; c++) wr(c, 32'h5A00_0000 ^ (c * 32'h0101_0103));
    chk_irq("R4");
    for (int c = NUM_CH - 1; c >= 0; c--) rd(c, "R2");
    begin
      logic [NUM_CH-1:0] all = '1;
      step(1'b0, 0, '0, all);
    end
    chk_irq("R6");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule